// File: doc/BRIEF.md
# Serial Host Command and Statistics Unit

This unit sits between a byte-wide serial receiver/transmitter pair and the control side of a partial-reconfiguration system. It watches the received byte stream for four-character ASCII command words. When it finds one, it gathers any operand that follows and then acts on it. The actions are: write the DMA length, the DMA start address or the port clock-frequency code; pulse a start request, either for the host-programmed transfer or for a stored image selected by index; switch into data mode; issue a soft reset; or queue a 32-bit counter value for transmission back to the host.

In data mode the received bytes are not decoded. They go out on a payload strobe, one per received byte, until the programmed length has been forwarded. The unit then drops back into command mode by itself.

Two cycle counters measure the system. The first times a whole reconfiguration, from the start request to the completion input. The second counts only the cycles in which the configuration port is being written during that window. A bank of use counters, one per stored image, records how often each image has been started by index.

Top module: `host_cmd_unit`

## Requirements
- R1: After reset every output is zero: no transmit byte pending, command mode, zero length, address, code and pointer index, no pulses.
- R2: The words "LENG", "ADDR" and "CLKF" are each followed by a 4-byte big-endian operand. When the last operand byte arrives, the operand is written to the DMA length, to the DMA address, or (its low CODE_W bits) to the clock code. The new value is visible in the next cycle.
- R3: Command words are ASCII, first character received first. Recognition uses the last four bytes received, so bytes that do not complete a known word are dropped and a valid word that follows stray bytes is still found.
- R4: "DATA" with a nonzero length raises the DMA enable. Each later byte appears on the payload port one cycle after it arrives and is not decoded. The enable drops on the cycle after the last of the programmed length is forwarded. With a zero length, "DATA" has no effect.
- R5: "GOHR" produces a one-cycle start pulse for the host-set transfer in the cycle after its last byte.
- R6: "GOPT" with operand index below N_IMG produces a one-cycle pointer-start pulse and presents the index. An index of N_IMG or more produces no pulse and changes nothing.
- R7: Counter 1 is cleared by any start. It then counts every cycle from the one after the start through the cycle in which the completion input is seen, and it holds its value after that.
- R8: Counter 2 is cleared by any start. Within the same window it counts only the cycles in which the port-write input is high.
- R9: Every accepted pointer start adds one to that image's use count. "RDUS" with a 4-byte index returns that count, or zero for an index out of range.
- R10: "RDC1", "RDC2" and "RDUS" return the 32-bit value held in the cycle of their last byte, as 4 bytes, most significant first. Each byte is held on the transmit port until accepted. A read that completes while a response is still being sent is dropped.
- R11: "RSET" pulses the soft-reset output for one cycle. It clears the length, address, code, pointer index, mode, counters, use counts and any pending response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter accepts the presented byte |
| tx_valid_o | output | 1 | Response byte presented |
| tx_byte_o | output | 8 | Response byte |
| cfg_done_i | input | 1 | Reconfiguration completion |
| port_wr_act_i | input | 1 | Configuration port write in progress |
| soft_rst_o | output | 1 | Soft-reset pulse to controlled logic |
| dma_len_o | output | LEN_W | DMA byte length |
| dma_addr_o | output | ADR_W | DMA start address |
| dma_en_o | output | 1 | Data mode / DMA enabled |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_byte_o | output | 8 | Payload byte |
| go_host_o | output | 1 | Start pulse using host-set address and length |
| go_ptr_o | output | 1 | Start pulse using stored image index |
| ptr_idx_o | output | IDX_W | Stored image index |
| clk_code_o | output | CODE_W | Port clock-frequency code |

## Verification
A behavioural reference model sees the same byte stream and is compared with every output on each cycle. The streams are varied so that each exposes a different class of fault. Clean command words with big-endian operands confirm operand byte order. A word buried in stray bytes confirms that the window slides rather than being framed. A payload that itself spells a command word shows whether data mode really stops decoding. A zero length and an out-of-range index confirm that the guards work. Counter reads are issued after windows with a known mix of port-write cycles, after a spurious completion, and while the transmitter is stalled, so that the counting window, the snapshot timing and the drop-while-busy rule each give distinct bytes.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;

   localparam int unsigned MNEM_BYTES = 4;
   localparam int unsigned OPND_BYTES = 4;
   localparam int unsigned RSP_BYTES  = 4;
   localparam int unsigned WORD_W     = 8 * OPND_BYTES;

   typedef enum logic [3:0] {
      CMD_NONE, CMD_RSET, CMD_LENG, CMD_ADDR, CMD_CMDM, CMD_DATA,
      CMD_GOHR, CMD_GOPT, CMD_RDC1, CMD_RDC2, CMD_RDUS, CMD_CLKF
   } cmd_e;

   // ASCII word, first received character in the top byte
   function automatic cmd_e mnem_decode(input logic [8*MNEM_BYTES-1:0] w);
      case (w)
         "RSET":  return CMD_RSET;
         "LENG":  return CMD_LENG;
         "ADDR":  return CMD_ADDR;
         "CMDM":  return CMD_CMDM;
         "DATA":  return CMD_DATA;
         "GOHR":  return CMD_GOHR;
         "GOPT":  return CMD_GOPT;
         "RDC1":  return CMD_RDC1;
         "RDC2":  return CMD_RDC2;
         "RDUS":  return CMD_RDUS;
         "CLKF":  return CMD_CLKF;
         default: return CMD_NONE;
      endcase
   endfunction

   function automatic logic takes_operand(input cmd_e c);
      return (c == CMD_LENG) || (c == CMD_ADDR) || (c == CMD_GOPT) ||
             (c == CMD_RDUS) || (c == CMD_CLKF);
   endfunction

endpackage

// File: rtl/host_cmd_parser.sv
module host_cmd_parser
   import host_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [7:0]        in_byte,
   output logic              fire_o,
   output cmd_e              cmd_o,
   output logic [WORD_W-1:0] arg_o
);

   localparam int unsigned HIST_W = 8 * (MNEM_BYTES - 1);
   localparam int unsigned OPSH_W = 8 * (OPND_BYTES - 1);
   localparam int unsigned WC_W   = $clog2(MNEM_BYTES);
   localparam int unsigned OC_W   = $clog2(OPND_BYTES);

   logic [HIST_W-1:0] win_q;
   logic [WC_W-1:0]   wcnt_q;
   logic              opnd_q;
   logic [OC_W-1:0]   ocnt_q;
   logic [OPSH_W-1:0] opw_q;
   cmd_e              pend_q;

   logic              win_full;
   logic              ops_last;
   cmd_e              hit;

   assign win_full = (wcnt_q == WC_W'(MNEM_BYTES - 1));
   assign ops_last = (ocnt_q == OC_W'(OPND_BYTES - 1));
   assign hit      = mnem_decode({win_q, in_byte});

   always_comb begin
      fire_o = 1'b0;
      cmd_o  = CMD_NONE;
      arg_o  = '0;
      if (in_vld) begin
         if (opnd_q) begin
            if (ops_last) begin
               fire_o = 1'b1;
               cmd_o  = pend_q;
               arg_o  = {opw_q, in_byte};
            end
         end else if (win_full && (hit != CMD_NONE) && !takes_operand(hit)) begin
            fire_o = 1'b1;
            cmd_o  = hit;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         wcnt_q <= '0;
         opnd_q <= 1'b0;
         ocnt_q <= '0;
         opw_q  <= '0;
         pend_q <= CMD_NONE;
      end else if (in_vld) begin
         if (opnd_q) begin
            opw_q  <= {opw_q[OPSH_W-9:0], in_byte};
            ocnt_q <= ocnt_q + OC_W'(1);
            if (ops_last) begin
               opnd_q <= 1'b0;
               wcnt_q <= '0;
            end
         end else if (win_full && (hit != CMD_NONE)) begin
            wcnt_q <= '0;
            if (takes_operand(hit)) begin
               opnd_q <= 1'b1;
               ocnt_q <= '0;
               pend_q <= hit;
            end
         end else begin
            win_q <= {win_q[HIST_W-9:0], in_byte};
            if (!win_full) wcnt_q <= wcnt_q + WC_W'(1);
         end
      end
   end

endmodule

// File: rtl/host_cmd_stats.sv
module host_cmd_stats #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned USE_W   = 16,
   parameter int unsigned N_IMG   = 8,
   parameter int unsigned IDX_W   = 3,
   parameter bit          USE_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             ptr_hit,
   input  logic [IDX_W-1:0] ptr_idx,
   input  logic             done_i,
   input  logic             wr_act_i,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] c1_o,
   output logic [CNT_W-1:0] c2_o,
   output logic [USE_W-1:0] use_o
);

   logic             run_q;
   logic [CNT_W-1:0] c1_q, c2_q;
   logic [USE_W-1:0] use_w [N_IMG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         c1_q  <= '0;
         c2_q  <= '0;
      end else if (clr) begin
         run_q <= 1'b0;
         c1_q  <= '0;
         c2_q  <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         c1_q  <= '0;
         c2_q  <= '0;
      end else if (run_q) begin
         c1_q <= c1_q + CNT_W'(1);
         if (wr_act_i) c2_q <= c2_q + CNT_W'(1);
         if (done_i)   run_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < N_IMG; i++) begin : g_img
      logic             bump;
      logic [USE_W-1:0] q;
      assign bump     = ptr_hit && (ptr_idx == IDX_W'(i));
      assign use_w[i] = q;
      if (USE_SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q <= '0;
            else if (clr)                q <= '0;
            else if (bump && (q != '1))  q <= q + USE_W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (clr)  q <= '0;
            else if (bump) q <= q + USE_W'(1);
         end
      end
   end

   assign c1_o  = c1_q;
   assign c2_o  = c2_q;
   assign use_o = use_w[rd_idx];

endmodule

// File: rtl/host_cmd_txser.sv
module host_cmd_txser #(
   parameter int unsigned NBYTES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic [8*NBYTES-1:0] word,
   input  logic                tx_ready_i,
   output logic                tx_valid_o,
   output logic [7:0]          tx_byte_o
);

   localparam int unsigned SH_W = 8 * NBYTES;
   localparam int unsigned CW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   logic [SH_W-1:0] sh_q;
   logic [CW-1:0]   cnt_q;
   logic            vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         vld_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         vld_q <= 1'b0;
      end else if (vld_q) begin
         if (tx_ready_i) begin
            sh_q  <= sh_q << 8;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(NBYTES - 1)) vld_q <= 1'b0;
         end
      end else if (load) begin
         sh_q  <= word;
         cnt_q <= '0;
         vld_q <= 1'b1;
      end
   end

   assign tx_valid_o = vld_q;
   assign tx_byte_o  = sh_q[SH_W-1 -: 8];

endmodule

// File: rtl/host_cmd_unit.sv
module host_cmd_unit
   import host_cmd_pkg::*;
#(
   parameter int unsigned LEN_W   = 32,
   parameter int unsigned ADR_W   = 32,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned USE_W   = 16,
   parameter int unsigned N_IMG   = 8,
   parameter int unsigned CODE_W  = 8,
   parameter bit          USE_SAT = 1'b1,
   localparam int unsigned IDX_W  = (N_IMG > 1) ? $clog2(N_IMG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   input  logic              tx_ready_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_byte_o,
   input  logic              cfg_done_i,
   input  logic              port_wr_act_i,
   output logic              soft_rst_o,
   output logic [LEN_W-1:0]  dma_len_o,
   output logic [ADR_W-1:0]  dma_addr_o,
   output logic              dma_en_o,
   output logic              pay_valid_o,
   output logic [7:0]        pay_byte_o,
   output logic              go_host_o,
   output logic              go_ptr_o,
   output logic [IDX_W-1:0]  ptr_idx_o,
   output logic [CODE_W-1:0] clk_code_o
);

   localparam int unsigned RSP_W = 8 * RSP_BYTES;

   if (LEN_W < 1 || LEN_W > WORD_W) begin : g_chk_len
      $error("LEN_W must lie in 1..32");
   end
   if (ADR_W < 1 || ADR_W > WORD_W) begin : g_chk_adr
      $error("ADR_W must lie in 1..32");
   end
   if (CODE_W < 1 || CODE_W > WORD_W) begin : g_chk_code
      $error("CODE_W must lie in 1..32");
   end
   if (CNT_W < 1 || CNT_W > RSP_W || USE_W < 1 || USE_W > RSP_W) begin : g_chk_cnt
      $error("counter widths must fit a response word");
   end
   if (N_IMG < 1) begin : g_chk_img
      $error("N_IMG must be at least 1");
   end

   logic              fire;
   cmd_e              cmd;
   logic [WORD_W-1:0] arg;
   logic              idx_ok, rset, start, ptr_hit, rd_load;
   logic [IDX_W-1:0]  rd_idx;
   logic [CNT_W-1:0]  c1, c2;
   logic [USE_W-1:0]  use_cnt;
   logic [RSP_W-1:0]  rsp;

   logic              srst_q, en_q, pv_q, gh_q, gp_q;
   logic [LEN_W-1:0]  len_q, rem_q;
   logic [ADR_W-1:0]  adr_q;
   logic [CODE_W-1:0] code_q;
   logic [7:0]        pb_q;
   logic [IDX_W-1:0]  pi_q;

   host_cmd_parser u_parse (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (rx_valid_i && !en_q),
      .in_byte (rx_byte_i),
      .fire_o  (fire),
      .cmd_o   (cmd),
      .arg_o   (arg)
   );

   assign idx_ok  = (arg < WORD_W'(N_IMG));
   assign rset    = fire && (cmd == CMD_RSET);
   assign ptr_hit = fire && (cmd == CMD_GOPT) && idx_ok;
   assign start   = ptr_hit || (fire && (cmd == CMD_GOHR));
   assign rd_idx  = idx_ok ? arg[IDX_W-1:0] : '0;
   assign rd_load = fire && ((cmd == CMD_RDC1) || (cmd == CMD_RDC2) || (cmd == CMD_RDUS));

   host_cmd_stats #(
      .CNT_W   (CNT_W),
      .USE_W   (USE_W),
      .N_IMG   (N_IMG),
      .IDX_W   (IDX_W),
      .USE_SAT (USE_SAT)
   ) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rset),
      .start    (start),
      .ptr_hit  (ptr_hit),
      .ptr_idx  (rd_idx),
      .done_i   (cfg_done_i),
      .wr_act_i (port_wr_act_i),
      .rd_idx   (rd_idx),
      .c1_o     (c1),
      .c2_o     (c2),
      .use_o    (use_cnt)
   );

   always_comb begin
      case (cmd)
         CMD_RDC1: rsp = RSP_W'(c1);
         CMD_RDC2: rsp = RSP_W'(c2);
         CMD_RDUS: rsp = idx_ok ? RSP_W'(use_cnt) : '0;
         default:  rsp = '0;
      endcase
   end

   host_cmd_txser #(
      .NBYTES (RSP_BYTES)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (rset),
      .load       (rd_load),
      .word       (rsp),
      .tx_ready_i (tx_ready_i),
      .tx_valid_o (tx_valid_o),
      .tx_byte_o  (tx_byte_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         en_q   <= 1'b0;
         pv_q   <= 1'b0;
         gh_q   <= 1'b0;
         gp_q   <= 1'b0;
         len_q  <= '0;
         rem_q  <= '0;
         adr_q  <= '0;
         code_q <= '0;
         pb_q   <= '0;
         pi_q   <= '0;
      end else begin
         srst_q <= 1'b0;
         pv_q   <= 1'b0;
         gh_q   <= 1'b0;
         gp_q   <= 1'b0;
         if (rx_valid_i && en_q) begin
            pv_q  <= 1'b1;
            pb_q  <= rx_byte_i;
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) en_q <= 1'b0;
         end
         if (fire) begin
            case (cmd)
               CMD_RSET: begin
                  srst_q <= 1'b1;
                  en_q   <= 1'b0;
                  len_q  <= '0;
                  rem_q  <= '0;
                  adr_q  <= '0;
                  code_q <= '0;
                  pb_q   <= '0;
                  pi_q   <= '0;
               end
               CMD_LENG: len_q  <= arg[LEN_W-1:0];
               CMD_ADDR: adr_q  <= arg[ADR_W-1:0];
               CMD_CLKF: code_q <= arg[CODE_W-1:0];
               CMD_CMDM: en_q   <= 1'b0;
               CMD_DATA: begin
                  if (len_q != '0) begin
                     en_q  <= 1'b1;
                     rem_q <= len_q;
                  end
               end
               CMD_GOHR: gh_q <= 1'b1;
               CMD_GOPT: begin
                  if (idx_ok) begin
                     gp_q <= 1'b1;
                     pi_q <= arg[IDX_W-1:0];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign soft_rst_o  = srst_q;
   assign dma_len_o   = len_q;
   assign dma_addr_o  = adr_q;
   assign dma_en_o    = en_q;
   assign pay_valid_o = pv_q;
   assign pay_byte_o  = pb_q;
   assign go_host_o   = gh_q;
   assign go_ptr_o    = gp_q;
   assign ptr_idx_o   = pi_q;
   assign clk_code_o  = code_q;

endmodule

// File: rtl/host_cmd_unit_chk.sv
module host_cmd_unit_chk #(
   parameter int unsigned LEN_W  = 32,
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_ready_i,
   input logic              tx_valid_o,
   input logic [7:0]        tx_byte_o,
   input logic              soft_rst_o,
   input logic [LEN_W-1:0]  dma_len_o,
   input logic              dma_en_o,
   input logic              pay_valid_o,
   input logic              go_host_o,
   input logic              go_ptr_o,
   input logic [CODE_W-1:0] clk_code_o
);

   // R5
   go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_host_o && go_ptr_o));

   // R5
   go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_host_o |=> !go_host_o);

   // R4
   pay_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid_o |-> $past(dma_en_o));

   // R4
   mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_en_o) |-> pay_valid_o);

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

   // R11
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (dma_len_o == '0 && clk_code_o == '0 && !dma_en_o && !tx_valid_o));

endmodule

bind host_cmd_unit host_cmd_unit_chk #(
   .LEN_W  (LEN_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_ready_i  (tx_ready_i),
   .tx_valid_o  (tx_valid_o),
   .tx_byte_o   (tx_byte_o),
   .soft_rst_o  (soft_rst_o),
   .dma_len_o   (dma_len_o),
   .dma_en_o    (dma_en_o),
   .pay_valid_o (pay_valid_o),
   .go_host_o   (go_host_o),
   .go_ptr_o    (go_ptr_o),
   .clk_code_o  (clk_code_o)
);

// File: tb/sim_host_cmd_unit.sv
module sim_host_cmd_unit;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        tx_ready = 1'b0;
   logic        done = 1'b0;
   logic        wr = 1'b0;
   logic        hold = 1'b0;

   logic        tx_valid_o, soft_rst_o, dma_en_o, pay_valid_o, go_host_o, go_ptr_o;
   logic [7:0]  tx_byte_o, pay_byte_o, clk_code_o;
   logic [31:0] dma_len_o, dma_addr_o;
   logic [2:0]  ptr_idx_o;

   host_cmd_unit u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_valid_i    (rx_valid),
      .rx_byte_i     (rx_byte),
      .tx_ready_i    (tx_ready),
      .tx_valid_o    (tx_valid_o),
      .tx_byte_o     (tx_byte_o),
      .cfg_done_i    (done),
      .port_wr_act_i (wr),
      .soft_rst_o    (soft_rst_o),
      .dma_len_o     (dma_len_o),
      .dma_addr_o    (dma_addr_o),
      .dma_en_o      (dma_en_o),
      .pay_valid_o   (pay_valid_o),
      .pay_byte_o    (pay_byte_o),
      .go_host_o     (go_host_o),
      .go_ptr_o      (go_ptr_o),
      .ptr_idx_o     (ptr_idx_o),
      .clk_code_o    (clk_code_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // transmitter acceptance pattern, can be stalled
   int tcnt = 0;
   always @(negedge clk) begin
      tcnt++;
      tx_ready <= !hold && ((tcnt % 3) != 0);
   end

   // ---------------- reference model ----------------
   logic [31:0] e_len, e_addr, e_rem, c1, c2;
   logic [7:0]  e_code, e_pb;
   bit          e_en, e_pv, e_gh, e_gp, e_srst, run, m_start;
   int          e_pi;
   int unsigned uses [8];
   byte unsigned txq [$];
   byte unsigned win [$];
   bit          opm;
   logic [31:0] opcmd, opw;
   int          opcnt;

   function automatic bit known(input logic [31:0] w);
      return w inside {"RSET","LENG","ADDR","CMDM","DATA","GOHR","GOPT",
                       "RDC1","RDC2","RDUS","CLKF"};
   endfunction

   function automatic bit wants_op(input logic [31:0] w);
      return w inside {"LENG","ADDR","GOPT","RDUS","CLKF"};
   endfunction

   task automatic m_clear();
      e_len = 0; e_addr = 0; e_rem = 0; e_code = 0; e_pb = 0; e_pi = 0;
      e_en = 0; c1 = 0; c2 = 0; run = 0;
      foreach (uses[k]) uses[k] = 0;
      txq.delete();
   endtask

   task automatic m_push(input logic [31:0] v);
      for (int k = 3; k >= 0; k--) txq.push_back(v[8*k +: 8]);
   endtask

   task automatic m_exec(input logic [31:0] w, input logic [31:0] a,
                         input bit busy, input logic [31:0] s1, input logic [31:0] s2);
      case (w)
         "RSET": e_srst = 1;
         "LENG": e_len = a;
         "ADDR": e_addr = a;
         "CLKF": e_code = a[7:0];
         "CMDM": e_en = 0;
         "DATA": if (e_len != 0) begin e_en = 1; e_rem = e_len; end
         "GOHR": begin e_gh = 1; m_start = 1; end
         "GOPT": if (a < 8) begin
                    e_gp = 1; e_pi = a; m_start = 1;
                    if (uses[a] < 65535) uses[a]++;
                 end
         "RDC1": if (!busy) m_push(s1);
         "RDC2": if (!busy) m_push(s2);
         "RDUS": if (!busy) m_push((a < 8) ? uses[a] : 0);
         default: ;
      endcase
   endtask

   always @(posedge clk) begin : model
      bit          busy;
      logic [31:0] s1, s2, w;
      if (!rst_n) begin
         m_clear();
         win.delete();
         opm = 0; opcnt = 0;
         e_pv = 0; e_gh = 0; e_gp = 0; e_srst = 0;
      end else begin
         busy = (txq.size() != 0);
         s1 = c1; s2 = c2;
         if (busy && tx_ready) void'(txq.pop_front());
         e_pv = 0; e_gh = 0; e_gp = 0; e_srst = 0; m_start = 0;
         if (rx_valid) begin
            if (e_en) begin
               e_pv = 1; e_pb = rx_byte; e_rem = e_rem - 1;
               if (e_rem == 0) e_en = 0;
            end else if (opm) begin
               opw = {opw[23:0], rx_byte};
               opcnt++;
               if (opcnt == 4) begin
                  opm = 0;
                  m_exec(opcmd, opw, busy, s1, s2);
               end
            end else begin
               win.push_back(rx_byte);
               if (win.size() > 4) void'(win.pop_front());
               if (win.size() == 4) begin
                  w = {win[0], win[1], win[2], win[3]};
                  if (known(w)) begin
                     win.delete();
                     if (wants_op(w)) begin opm = 1; opcnt = 0; opcmd = w; end
                     else m_exec(w, 0, busy, s1, s2);
                  end
               end
            end
         end
         if (m_start) begin c1 = 0; c2 = 0; run = 1; end
         else if (run) begin
            c1 = c1 + 1;
            if (wr) c2 = c2 + 1;
            if (done) run = 0;
         end
         if (e_srst) m_clear();
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2 dma_len", dma_len_o, e_len);
         chk("R2 dma_addr", dma_addr_o, e_addr);
         chk("R2 clk_code", {24'd0, clk_code_o}, {24'd0, e_code});
         chk("R4 dma_en", {31'd0, dma_en_o}, {31'd0, e_en});
         chk("R4 pay_valid", {31'd0, pay_valid_o}, {31'd0, e_pv});
         chk("R4 pay_byte", {24'd0, pay_byte_o}, {24'd0, e_pb});
         chk("R5 go_host (R3 resync)", {31'd0, go_host_o}, {31'd0, e_gh});
         chk("R6 go_ptr", {31'd0, go_ptr_o}, {31'd0, e_gp});
         chk("R6 ptr_idx", {29'd0, ptr_idx_o}, 32'(e_pi));
         chk("R11 soft_rst", {31'd0, soft_rst_o}, {31'd0, e_srst});
         chk("R10 tx_valid", {31'd0, tx_valid_o}, {31'd0, (txq.size() != 0)});
         if (txq.size() != 0)
            chk("R10 tx_byte (R7/R8/R9 counter value)", {24'd0, tx_byte_o}, {24'd0, txq[0]});
      end
   end

   // ---------------- stimulus ----------------
   task automatic send_b(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_w(input logic [31:0] w);
      for (int k = 3; k >= 0; k--) send_b(w[8*k +: 8]);
   endtask

   task automatic wait_tx();
      repeat (2) @(negedge clk);
      while (tx_valid_o) @(negedge clk);
   endtask

   task automatic drive(input bit d, input bit a, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         done = d;
         wr   = a;
      end
      @(negedge clk);
      done = 1'b0;
      wr   = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1 reset flags", {26'd0, tx_valid_o, dma_en_o, pay_valid_o, go_host_o, go_ptr_o, soft_rst_o}, 0);
      chk("R1 reset len", dma_len_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset code/idx", {21'd0, ptr_idx_o, clk_code_o}, 0);

      // R2: operands, big-endian
      send_w("LENG"); send_w(32'h0000_0005);
      send_w("ADDR"); send_w(32'h1234_ABCD);
      send_w("CLKF"); send_w(32'h0000_01A5);

      // R3 + R5: stray bytes before a valid word
      send_b("Z"); send_b("G"); send_b("O");
      send_w("GOHR");
      // R7/R8: 5 write cycles, idle, completion, then a stray completion
      drive(0, 1, 5);
      drive(0, 0, 2);
      drive(1, 1, 1);
      drive(0, 1, 3);
      drive(1, 0, 1);
      send_w("RDC1"); wait_tx();
      send_w("RDC2"); wait_tx();

      // R4: payload that spells a command is forwarded, not decoded
      send_w("DATA");
      send_w("RSET");
      send_b("Q");
      send_w("CMDM");
      // R4: zero length leaves command mode
      send_w("LENG"); send_w(32'h0);
      send_w("DATA");
      send_w("CLKF"); send_w(32'h0000_0033);

      // R6/R9: pointer starts, one out of range
      send_w("GOPT"); send_w(32'd3);
      drive(0, 1, 4);
      drive(1, 0, 1);
      send_w("GOPT"); send_w(32'd3);
      send_w("GOPT"); send_w(32'd7);
      send_w("GOPT"); send_w(32'd9);
      send_w("RDUS"); send_w(32'd3); wait_tx();
      send_w("RDUS"); send_w(32'd9); wait_tx();
      send_w("RDC2"); wait_tx();

      // R10: read while a response is stalled is dropped
      hold = 1'b1;
      send_w("RDUS"); send_w(32'd7);
      send_w("RDC1");
      repeat (4) @(negedge clk);
      hold = 1'b0;
      wait_tx();

      // R11: soft reset clears state and counts
      send_w("LENG"); send_w(32'h0000_0040);
      send_w("RSET");
      send_w("RDUS"); send_w(32'd3); wait_tx();
      send_w("RDC1"); wait_tx();

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule